// File: doc/BRIEF.md
# Duty-Cycled Address Gate with Word Budget

This block sits on the read-address and write-address channels of a memory-mapped bus. It models competing traffic by letting addresses through only during part of a repeating schedule. Each schedule period starts with an open window of a programmable number of cycles. A closed window of a programmable number of cycles follows it. Within one period, the addresses accepted may together ask for no more than a programmable number of 64-bit data words.

An address is charged its burst length plus one words. The budget refills to the cap on every entry into an open window, and a cap of zero removes the limit. An address that is already presented downstream and not yet accepted stays presented until its handshake completes. Closing the gate therefore never withdraws a valid address. The data channels and any latency shaping are outside this block.

Top module: `addr_duty_gate`

## Requirements
- R1: While `rstN` is low at a clock edge, the block enters the first cycle of an open window with the budget equal to `capWords`. The window is open in that cycle unless `onCycles` is 0 and `offCycles` is nonzero.
- R2: With `onCycles` and `offCycles` both nonzero, `gateOpen` is 1 for `onCycles` cycles, then 0 for `offCycles` cycles, and the pattern repeats.
- R3: With `offCycles` equal to 0, `gateOpen` is always 1. A new period, and so a budget refill, starts every `onCycles` cycles, or every cycle when `onCycles` is also 0.
- R4: With `onCycles` equal to 0 and `offCycles` nonzero, `gateOpen` is always 0.
- R5: While the gate is closed, an address that is not already held is not passed on: its downstream valid and upstream ready are both 0.
- R6: With a nonzero cap, an address is passed only if the remaining budget is at least its length field plus 1. Each completed handshake subtracts that amount, and the result saturates at 0.
- R7: A cap of 0 means unlimited: while open, every address passes regardless of its length.
- R8: The budget reloads to `capWords` at the start of every open window. A charge that falls in the same cycle is dropped.
- R9: The read channel has priority. When a read address is presented, the write address passes only if the budget covers the read cost plus the write cost.
- R10: An address that was presented downstream without `*ReadyIn` stays presented in the next cycle, whatever the gate state or the budget.
- R11: While a channel passes, its downstream valid follows its upstream valid and its upstream ready follows its downstream ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| onCycles | input | 16 | Length of the open window in cycles |
| offCycles | input | 16 | Length of the closed window in cycles |
| capWords | input | 16 | Words allowed per period, 0 for no limit |
| arValidIn | input | 1 | Read address valid from the manager |
| arLenIn | input | 8 | Read burst length field (beats minus one) |
| arReadyOut | output | 1 | Gated read address ready to the manager |
| arValidOut | output | 1 | Gated read address valid to the memory |
| arReadyIn | input | 1 | Read address ready from the memory |
| awValidIn | input | 1 | Write address valid from the manager |
| awLenIn | input | 8 | Write burst length field (beats minus one) |
| awReadyOut | output | 1 | Gated write address ready to the manager |
| awValidOut | output | 1 | Gated write address valid to the memory |
| awReadyIn | input | 1 | Write address ready from the memory |
| gateOpen | output | 1 | 1 while the schedule is in an open window |

## Verification
The assertions assume that the three configuration values stay constant between resets. They also assume that a manager keeps an address valid, with the same length, until its handshake completes. The bench applies a new configuration only while reset is held. It forces the upstream valid and length to stay unchanged whenever its own model says an address is held downstream, and it randomizes everything else. The configurations cover zero on-time, zero off-time, both zero, a cap of zero, a cap of one word, and lengths of up to 256 beats.

// File: rtl/agate_pkg.sv
`timescale 1ns/1ps
package agate_pkg;
  // strobes from the schedule control into the budget datapath
  typedef struct packed {
    logic gateOpen;  // current cycle lies in an open window
    logic reload;    // the next cycle starts a new open window
  } gateStrobes_t;
endpackage

// File: rtl/agate_ctrl.sv
`timescale 1ns/1ps
module agate_ctrl
  import agate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] onCycles,
  input  logic [CNT_W-1:0] offCycles,
  output gateStrobes_t     strobes
);
  localparam int EXT_W = CNT_W + 1;

  logic             phaseOn;
  logic [CNT_W-1:0] phaseCnt;
  logic             nextPhaseOn;
  logic [CNT_W-1:0] nextCnt;
  logic [EXT_W-1:0] cntPlusOne;
  logic             onZero;
  logic             offZero;
  logic             onDone;
  logic             offDone;
  logic             reloadNow;

  assign onZero     = (onCycles == '0);
  assign offZero    = (offCycles == '0);
  assign cntPlusOne = {1'b0, phaseCnt} + EXT_W'(1);
  assign onDone     = cntPlusOne >= {1'b0, onCycles};
  assign offDone    = cntPlusOne >= {1'b0, offCycles};

  always_comb begin
    nextPhaseOn = phaseOn;
    nextCnt     = phaseCnt + CNT_W'(1);
    reloadNow   = 1'b0;
    if (phaseOn) begin
      if (onDone) begin
        nextCnt = '0;
        if (offZero) reloadNow = 1'b1;     // no closed window: restart open
        else         nextPhaseOn = 1'b0;
      end
    end else begin
      if (offDone) begin
        nextCnt = '0;
        if (!onZero) begin
          nextPhaseOn = 1'b1;
          reloadNow   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseOn  <= 1'b1;
      phaseCnt <= '0;
    end else begin
      phaseOn  <= nextPhaseOn;
      phaseCnt <= nextCnt;
    end
  end

  assign strobes.gateOpen = offZero || (phaseOn && !onZero);
  assign strobes.reload   = reloadNow;

  AST_ON_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOn && !onZero) |-> ({1'b0, phaseCnt} < {1'b0, onCycles})) else $error("on count"); // R2
  AST_RELOAD_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> strobes.gateOpen) else $error("reload opens"); // R8
  AST_ZERO_ON_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (onZero && !offZero && !phaseOn) |=> !strobes.gateOpen) else $error("closed"); // R4
endmodule

// File: rtl/agate_chan.sv
`timescale 1ns/1ps
module agate_chan (
  input  logic clk,
  input  logic rstN,
  input  logic allow,
  input  logic validIn,
  input  logic readyIn,
  output logic validOut,
  output logic readyOut,
  output logic fire,
  output logic held
);
  logic pass;

  assign pass     = held || allow;
  assign validOut = validIn && pass;
  assign readyOut = readyIn && pass;
  assign fire     = validOut && readyIn;

  always_ff @(posedge clk) begin
    if (!rstN) held <= 1'b0;
    else       held <= validOut && !readyIn;
  end

  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyIn) |=> validOut) else $error("held dropped"); // R10
endmodule

// File: rtl/agate_datapath.sv
`timescale 1ns/1ps
module agate_datapath
  import agate_pkg::*;
#(
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobes_t     strobes,
  input  logic [CAP_W-1:0] capWords,
  input  logic             arValidIn,
  input  logic [LEN_W-1:0] arLenIn,
  input  logic             arReadyIn,
  output logic             arValidOut,
  output logic             arReadyOut,
  input  logic             awValidIn,
  input  logic [LEN_W-1:0] awLenIn,
  input  logic             awReadyIn,
  output logic             awValidOut,
  output logic             awReadyOut
);
  localparam int COST_W = LEN_W + 1;
  localparam int SUM_W  = ((CAP_W > COST_W + 1) ? CAP_W : COST_W + 1) + 1;

  logic [CAP_W-1:0] budget;
  logic [SUM_W-1:0] budgetExt;
  logic [SUM_W-1:0] arCost;
  logic [SUM_W-1:0] awCost;
  logic [SUM_W-1:0] awNeed;
  logic [SUM_W-1:0] charge;
  logic             capZero;
  logic             arAllow;
  logic             awAllow;
  logic             arFire;
  logic             awFire;
  logic             arHeld;
  logic             awHeld;

  assign capZero   = (capWords == '0);
  assign budgetExt = SUM_W'(budget);
  assign arCost    = SUM_W'(arLenIn) + SUM_W'(1);
  assign awCost    = SUM_W'(awLenIn) + SUM_W'(1);
  // read has priority: a presented read reserves its cost ahead of write
  assign awNeed    = awCost + (arValidIn ? arCost : '0);

  assign arAllow = strobes.gateOpen && (capZero || (budgetExt >= arCost));
  assign awAllow = strobes.gateOpen && (capZero || (budgetExt >= awNeed));

  agate_chan uArChan (
    .clk(clk), .rstN(rstN), .allow(arAllow),
    .validIn(arValidIn), .readyIn(arReadyIn),
    .validOut(arValidOut), .readyOut(arReadyOut),
    .fire(arFire), .held(arHeld)
  );

  agate_chan uAwChan (
    .clk(clk), .rstN(rstN), .allow(awAllow),
    .validIn(awValidIn), .readyIn(awReadyIn),
    .validOut(awValidOut), .readyOut(awReadyOut),
    .fire(awFire), .held(awHeld)
  );

  assign charge = (arFire ? arCost : '0) + (awFire ? awCost : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      budget <= capWords;
    end else if (strobes.reload || capZero) begin
      budget <= capWords;
    end else if (budgetExt >= charge) begin
      budget <= CAP_W'(budgetExt - charge);
    end else begin
      budget <= '0;
    end
  end

  AST_CLOSED_BLOCKS_AR: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.gateOpen && !arHeld) |-> (!arValidOut && !arReadyOut)) else $error("ar closed"); // R5
  AST_CLOSED_BLOCKS_AW: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.gateOpen && !awHeld) |-> (!awValidOut && !awReadyOut)) else $error("aw closed"); // R5
  AST_RELOAD_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> (budget == $past(capWords))) else $error("reload"); // R8
  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !capZero |-> (budget <= capWords)) else $error("bound"); // R6
  AST_BOTH_FIT: assert property (@(posedge clk) disable iff (!rstN)
    (!capZero && arFire && awFire && !arHeld && !awHeld) |-> (budgetExt >= arCost + awCost))
    else $error("both fit"); // R9
endmodule

// File: rtl/addr_duty_gate.sv
`timescale 1ns/1ps
module addr_duty_gate
  import agate_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] onCycles,
  input  logic [CNT_W-1:0] offCycles,
  input  logic [CAP_W-1:0] capWords,
  input  logic             arValidIn,
  input  logic [LEN_W-1:0] arLenIn,
  output logic             arReadyOut,
  output logic             arValidOut,
  input  logic             arReadyIn,
  input  logic             awValidIn,
  input  logic [LEN_W-1:0] awLenIn,
  output logic             awReadyOut,
  output logic             awValidOut,
  input  logic             awReadyIn,
  output logic             gateOpen
);
  gateStrobes_t strobes;

  agate_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .onCycles(onCycles), .offCycles(offCycles),
    .strobes(strobes)
  );

  agate_datapath #(.CAP_W(CAP_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .capWords(capWords),
    .arValidIn(arValidIn), .arLenIn(arLenIn), .arReadyIn(arReadyIn),
    .arValidOut(arValidOut), .arReadyOut(arReadyOut),
    .awValidIn(awValidIn), .awLenIn(awLenIn), .awReadyIn(awReadyIn),
    .awValidOut(awValidOut), .awReadyOut(awReadyOut)
  );

  assign gateOpen = strobes.gateOpen;
endmodule

// File: tb/tb_addr_duty_gate.sv
`timescale 1ns/1ps
module tb_addr_duty_gate;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] onCycles, offCycles, capWords;
  logic        arValidIn, arReadyIn, awValidIn, awReadyIn;
  logic [7:0]  arLenIn, awLenIn;
  logic        arReadyOut, arValidOut, awReadyOut, awValidOut, gateOpen;

  always #2.5 clk = ~clk;

  addr_duty_gate dut (
    .clk(clk), .rstN(rstN),
    .onCycles(onCycles), .offCycles(offCycles), .capWords(capWords),
    .arValidIn(arValidIn), .arLenIn(arLenIn), .arReadyOut(arReadyOut),
    .arValidOut(arValidOut), .arReadyIn(arReadyIn),
    .awValidIn(awValidIn), .awLenIn(awLenIn), .awReadyOut(awReadyOut),
    .awValidOut(awValidOut), .awReadyIn(awReadyIn),
    .gateOpen(gateOpen)
  );

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit openAt(int t, int on, int off);
    if (off == 0) return 1'b1;
    if (on == 0)  return 1'b0;
    return (t % (on + off)) < on;
  endfunction

  function automatic bit reloadAt(int t, int on, int off);
    if (off == 0) return (t % ((on == 0) ? 1 : on)) == 0;
    if (on == 0)  return 1'b0;
    return (t % (on + off)) == 0;
  endfunction

  task automatic runConfig(input int on, input int off, input int cap, input int cycles);
    int  budget;
    bit  arHeldM, awHeldM;
    onCycles = 16'(on); offCycles = 16'(off); capWords = 16'(cap);
    arValidIn = 0; awValidIn = 0; arReadyIn = 0; awReadyIn = 0;
    arLenIn = 0; awLenIn = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    budget = cap; arHeldM = 0; awHeldM = 0;
    for (int t = 0; t < cycles; t++) begin
      bit open, capZ, arPass, awPass, expArV, expAwV, arFire, awFire;
      int arCost, awCost;
      string tagAr, tagAw, tagG;
      if (!arHeldM) begin
        arValidIn = ($urandom % 10) < 6;
        arLenIn   = (($urandom % 16) == 0) ? 8'd255 : 8'($urandom % 8);
      end
      if (!awHeldM) begin
        awValidIn = ($urandom % 10) < 6;
        awLenIn   = (($urandom % 16) == 0) ? 8'd255 : 8'($urandom % 8);
      end
      arReadyIn = $urandom % 2;
      awReadyIn = $urandom % 2;
      #1;
      open   = openAt(t, on, off);
      capZ   = (cap == 0);
      arCost = int'(arLenIn) + 1;
      awCost = int'(awLenIn) + 1;
      arPass = arHeldM || (open && (capZ || budget >= arCost));
      awPass = awHeldM || (open && (capZ || budget >= awCost + (arValidIn ? arCost : 0)));
      expArV = arValidIn && arPass;
      expAwV = awValidIn && awPass;

      tagG = (t == 0) ? "R1" : (off == 0) ? "R3" : (on == 0) ? "R4" : "R2";
      chk(gateOpen == open, tagG, gateOpen, open);

      if (t == 0)            tagAr = "R1";
      else if (arHeldM)      tagAr = "R10";
      else if (!open)        tagAr = "R5";
      else if (capZ)         tagAr = "R7";
      else if (reloadAt(t, on, off)) tagAr = "R8";
      else                   tagAr = "R6";
      if (awHeldM)           tagAw = "R10";
      else if (!open)        tagAw = "R5";
      else if (capZ)         tagAw = "R7";
      else if (arValidIn)    tagAw = "R9";
      else                   tagAw = "R6";
      chk(arValidOut == expArV, tagAr, arValidOut, expArV);
      chk(awValidOut == expAwV, tagAw, awValidOut, expAwV);
      chk(arReadyOut == (arReadyIn && arPass), "R11", arReadyOut, arReadyIn && arPass);
      chk(awReadyOut == (awReadyIn && awPass), "R11", awReadyOut, awReadyIn && awPass);

      arFire = expArV && arReadyIn;
      awFire = expAwV && awReadyIn;
      @(posedge clk);
      if (reloadAt(t + 1, on, off)) budget = cap;
      else if (!capZ) begin
        budget = budget - (arFire ? arCost : 0) - (awFire ? awCost : 0);
        if (budget < 0) budget = 0;
      end
      arHeldM = expArV && !arReadyIn;
      awHeldM = expAwV && !awReadyIn;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // directed corners mixed with random traffic
    runConfig(5, 3, 0,  400);  // R7 unlimited cap
    runConfig(4, 4, 10, 400);  // R2 R6 R8
    runConfig(0, 0, 6,  400);  // R3 refill every cycle
    runConfig(6, 0, 20, 400);  // R3 refill each on-time
    runConfig(0, 5, 8,  400);  // R4 always closed
    runConfig(3, 2, 1,  400);  // R6 one-word cap
    runConfig(2, 7, 300, 400); // R9 R10 long closed windows
    runConfig(1, 1, 3,  400);  // R2 alternating
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule